// File: doc/BRIEF.md
# Interrupt Aggregation and GPIO Control Register File

This block is a byte-wide control register file for a peripheral companion chip. It sits on a simple 8-bit register bus: one address, write data, a write strobe and a combinational read-data return. It collects eight level-type interrupt requests from sub-functions into a status register. It raises a single interrupt line whenever a status bit is set and its mask bit is also set.

The block also holds a 24-bit output-level register and a 24-bit output-enable register, each written one byte at a time. Each of the 16 physical pins is driven with level AND enable. A small two-state sequencer (states `GS_IDLE` and `GS_NOTIFY`) publishes per-pin change pulses. Any write to a level or enable byte moves it from `GS_IDLE` to `GS_NOTIFY`, or keeps it in `GS_NOTIFY`. A cycle with no such write returns it to `GS_IDLE`. While in `GS_NOTIFY`, every pin whose driven value differs from the last published value pulses for that one cycle, and the published copy is updated.

Clock-control and PLL-control registers are plain storage. Every multi-byte register is little-endian across consecutive addresses, and a byte write touches only its own lane.

Top module: `sysctl_irq_gpio`

## Requirements
- R1: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to either offset change nothing.
- R2: The status register is at 0x50, the mask register at 0x52 and the routing register at 0x54, each 8 bits wide. Mask and routing read back what was last written.
- R3: When sub-interrupt input n changes level, status bit n takes the new level at the next clock edge. A rise sets the bit and a fall clears it.
- R4: `irq_out` is high exactly when the AND of status and mask is nonzero, as a combinational function of the registered status and mask.
- R5: A bus write to 0x50 loads all eight status bits from the write data. It overrides a sub-input change in the same cycle. A sub-input held steadily high does not set its bit again after software has cleared it.
- R6: The output-level register occupies 0x78 to 0x7A and the output-enable register occupies 0x7C to 0x7E. Byte i of each holds bits 8i+7 down to 8i, and both read back. `pin_out` equals the low 16 bits of level AND enable, and it changes only in the cycle after a write.
- R7: In the cycle after a write to any level or enable byte, `pin_event` is high for exactly the pins whose `pin_out` value differs from the last published value. In every other cycle `pin_event` is zero. A write to byte 2 therefore produces no pulse.
- R8: Clock control at 0x98 to 0x99 (16 bits) and PLL control at 0x9C to 0x9F (32 bits) read back each written byte lane, and a write leaves the other lanes unchanged.
- R9: Any offset not listed above reads 0x00, and writes to it have no effect (for example 0x51, 0x7B and 0x9A).
- R10: After reset, every register, `irq_out`, `pin_out` and `pin_event` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| sub_irq | input | 8 | Level interrupt requests from sub-functions |
| irq_out | output | 1 | Masked aggregate interrupt |
| pin_out | output | 16 | Driven pin values (level AND enable) |
| pin_event | output | 16 | One-cycle per-pin change pulses |

## Verification
Directed stimulus covers three status-register cases. A sub input rises, then falls, which separates level following from sticky setting. A software status write lands in the same cycle as a sub-input rise, which exposes priority. A steady-high input is left alone after a software clear, which separates edge detection from level copying.

GPIO stimulus first enables all pins, then writes bytes 0, 1 and 2 in turn. Byte 2 must produce no pulse. Changing enable alone must produce pulses just as a level change does.

A seeded random stream then mixes writes and reads across mapped and unmapped offsets with sparse sub-input toggles. Every cycle is compared against a bench model, which exposes lane mix-ups, lost bytes and aliasing of holes onto real registers.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned BUS_W      = 8;
    localparam logic [7:0]  OFF_REV_LO = 8'h08;
    localparam logic [7:0]  OFF_REV_HI = 8'h09;
    localparam logic [7:0]  OFF_STAT   = 8'h50;
    localparam logic [7:0]  OFF_MASK   = 8'h52;
    localparam logic [7:0]  OFF_ROUTE  = 8'h54;
    localparam logic [7:0]  OFF_LVL    = 8'h78;
    localparam logic [7:0]  OFF_OEN    = 8'h7C;
    localparam logic [7:0]  OFF_CLK    = 8'h98;
    localparam logic [7:0]  OFF_PLL    = 8'h9C;
    localparam logic [7:0]  REV_VALUE  = 8'h03;

    typedef enum logic [0:0] {
        GS_IDLE   = 1'b0,
        GS_NOTIFY = 1'b1
    } gpio_state_t;
endpackage

// File: rtl/byte_store.sv
module byte_store #(
    parameter int unsigned NBYTES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NBYTES-1:0]     lane_we,
    input  logic [7:0]            wdata,
    output logic [8*NBYTES-1:0]   q
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[8*g +: 8] <= '0;
            else if (lane_we[g])
                q[8*g +: 8] <= wdata;
        end
    end
endmodule

// File: rtl/irq_collect.sv
module irq_collect #(
    parameter int unsigned NSUB = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] sub_irq,
    input  logic            stat_we,
    input  logic            mask_we,
    input  logic [7:0]      wdata,
    output logic [NSUB-1:0] status,
    output logic [NSUB-1:0] mask,
    output logic            irq
);
    logic [NSUB-1:0] sub_q;
    logic [NSUB-1:0] changed;

    assign changed = sub_irq ^ sub_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= '0;
            status <= '0;
        end else begin
            sub_q <= sub_irq;
            if (stat_we)
                status <= wdata[NSUB-1:0];
            else
                status <= (status & ~changed) | (sub_irq & changed);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_we)
            mask <= wdata[NSUB-1:0];
    end

    assign irq = |(status & mask);

    for (genvar g = 0; g < NSUB; g++) begin : g_chk
        a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_we && $rose(sub_irq[g])) |=> status[g]);
        a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_we && $fell(sub_irq[g])) |=> !status[g]);
    end

    a_r5_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> (status == $past(wdata[NSUB-1:0])));

    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/gpio_publish.sv
module gpio_publish #(
    parameter int unsigned NBYTES = 3,
    parameter int unsigned PINS   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NBYTES-1:0]    lvl_we,
    input  logic [NBYTES-1:0]    oen_we,
    input  logic [7:0]           wdata,
    output logic [8*NBYTES-1:0]  level,
    output logic [8*NBYTES-1:0]  enable,
    output logic [PINS-1:0]      pin_out,
    output logic [PINS-1:0]      pin_event
);
    import sysctl_pkg::*;

    gpio_state_t     state_q, state_d;
    logic [PINS-1:0] shown_q;
    logic            any_wr;

    byte_store #(.NBYTES(NBYTES)) u_level (
        .clk(clk), .rst_n(rst_n), .lane_we(lvl_we), .wdata(wdata), .q(level)
    );
    byte_store #(.NBYTES(NBYTES)) u_enable (
        .clk(clk), .rst_n(rst_n), .lane_we(oen_we), .wdata(wdata), .q(enable)
    );

    assign any_wr  = |{lvl_we, oen_we};
    assign pin_out = level[PINS-1:0] & enable[PINS-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE:   if (any_wr)  state_d = GS_NOTIFY;
            GS_NOTIFY: if (!any_wr) state_d = GS_IDLE;
            default:   state_d = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            shown_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == GS_NOTIFY)
                shown_q <= pin_out;
        end
    end

    always_comb begin
        pin_event = '0;
        unique case (state_q)
            GS_IDLE:   pin_event = '0;
            GS_NOTIFY: pin_event = pin_out ^ shown_q;
            default:   pin_event = '0;
        endcase
    end

    a_r7_event_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_event) |-> $past(any_wr));
    a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(any_wr) |-> $stable(pin_out));
endmodule

// File: rtl/sysctl_irq_gpio.sv
module sysctl_irq_gpio #(
    parameter int unsigned NSUB      = 8,
    parameter int unsigned GPIO_BYTS = 3,
    parameter int unsigned PINS      = 16,
    parameter int unsigned CLK_BYTS  = 2,
    parameter int unsigned PLL_BYTS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    output logic [7:0]       bus_rdata,
    input  logic [NSUB-1:0]  sub_irq,
    output logic             irq_out,
    output logic [PINS-1:0]  pin_out,
    output logic [PINS-1:0]  pin_event
);
    import sysctl_pkg::*;

    logic [NSUB-1:0]          status, mask;
    logic [7:0]               route;
    logic [8*GPIO_BYTS-1:0]   level, enable;
    logic [8*CLK_BYTS-1:0]    clk_cfg;
    logic [8*PLL_BYTS-1:0]    pll_cfg;
    logic [GPIO_BYTS-1:0]     lvl_we, oen_we;
    logic [CLK_BYTS-1:0]      clk_we;
    logic [PLL_BYTS-1:0]      pll_we;
    logic                     stat_we, mask_we;
    logic [0:0]               route_we;

    assign stat_we     = bus_we && (bus_addr == OFF_STAT);
    assign mask_we     = bus_we && (bus_addr == OFF_MASK);
    assign route_we[0] = bus_we && (bus_addr == OFF_ROUTE);

    for (genvar g = 0; g < GPIO_BYTS; g++) begin : g_gdec
        assign lvl_we[g] = bus_we && (bus_addr == OFF_LVL + 8'(g));
        assign oen_we[g] = bus_we && (bus_addr == OFF_OEN + 8'(g));
    end
    for (genvar g = 0; g < CLK_BYTS; g++) begin : g_cdec
        assign clk_we[g] = bus_we && (bus_addr == OFF_CLK + 8'(g));
    end
    for (genvar g = 0; g < PLL_BYTS; g++) begin : g_pdec
        assign pll_we[g] = bus_we && (bus_addr == OFF_PLL + 8'(g));
    end

    irq_collect #(.NSUB(NSUB)) u_irq (
        .clk(clk), .rst_n(rst_n), .sub_irq(sub_irq), .stat_we(stat_we),
        .mask_we(mask_we), .wdata(bus_wdata), .status(status), .mask(mask),
        .irq(irq_out)
    );

    gpio_publish #(.NBYTES(GPIO_BYTS), .PINS(PINS)) u_gpio (
        .clk(clk), .rst_n(rst_n), .lvl_we(lvl_we), .oen_we(oen_we),
        .wdata(bus_wdata), .level(level), .enable(enable),
        .pin_out(pin_out), .pin_event(pin_event)
    );

    byte_store #(.NBYTES(1)) u_route (
        .clk(clk), .rst_n(rst_n), .lane_we(route_we), .wdata(bus_wdata), .q(route)
    );
    byte_store #(.NBYTES(CLK_BYTS)) u_clk (
        .clk(clk), .rst_n(rst_n), .lane_we(clk_we), .wdata(bus_wdata), .q(clk_cfg)
    );
    byte_store #(.NBYTES(PLL_BYTS)) u_pll (
        .clk(clk), .rst_n(rst_n), .lane_we(pll_we), .wdata(bus_wdata), .q(pll_cfg)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_REV_LO) bus_rdata = REV_VALUE;
        if (bus_addr == OFF_STAT)   bus_rdata = 8'(status);
        if (bus_addr == OFF_MASK)   bus_rdata = 8'(mask);
        if (bus_addr == OFF_ROUTE)  bus_rdata = route;
        for (int i = 0; i < int'(GPIO_BYTS); i++) begin
            if (bus_addr == OFF_LVL + 8'(i)) bus_rdata = level[8*i +: 8];
            if (bus_addr == OFF_OEN + 8'(i)) bus_rdata = enable[8*i +: 8];
        end
        for (int i = 0; i < int'(CLK_BYTS); i++)
            if (bus_addr == OFF_CLK + 8'(i)) bus_rdata = clk_cfg[8*i +: 8];
        for (int i = 0; i < int'(PLL_BYTS); i++)
            if (bus_addr == OFF_PLL + 8'(i)) bus_rdata = pll_cfg[8*i +: 8];
    end

    a_r1_revid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_REV_LO) |-> (bus_rdata == 8'h03));
    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h51 || bus_addr == OFF_REV_HI) |-> (bus_rdata == 8'h00));
    a_r4_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status != '0));
endmodule

// File: tb/sysctl_irq_gpio_tb_top.sv
module sysctl_irq_gpio_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        bus_we = 1'b0;
    logic [7:0]  sub_irq = '0;
    logic        irq_out;
    logic [15:0] pin_out, pin_event;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  m_stat, m_mask, m_route, m_subq;
    logic [23:0] m_lvl, m_en;
    logic [15:0] m_clk, m_evt;
    logic [31:0] m_pll;

    sysctl_irq_gpio dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .sub_irq(sub_irq),
        .irq_out(irq_out), .pin_out(pin_out), .pin_event(pin_event)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h08: return 8'h03;
            8'h50: return m_stat;
            8'h52: return m_mask;
            8'h54: return m_route;
            8'h78, 8'h79, 8'h7A: return m_lvl[8*(a-8'h78) +: 8];
            8'h7C, 8'h7D, 8'h7E: return m_en[8*(a-8'h7C) +: 8];
            8'h98, 8'h99: return m_clk[8*(a-8'h98) +: 8];
            8'h9C, 8'h9D, 8'h9E, 8'h9F: return m_pll[8*(a-8'h9C) +: 8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h08, 8'h09: return "R1";
            8'h50: return "R3";
            8'h52, 8'h54: return "R2";
            8'h78, 8'h79, 8'h7A, 8'h7C, 8'h7D, 8'h7E: return "R6";
            8'h98, 8'h99, 8'h9C, 8'h9D, 8'h9E, 8'h9F: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [15:0] eff();
        return m_lvl[15:0] & m_en[15:0];
    endfunction

    // one bus cycle: drive now (at a negedge), model at the edge, check at next negedge
    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] sub);
        logic [7:0]  chg;
        logic [15:0] old_eff;
        bit          gw;
        bus_we = we; bus_addr = a; bus_wdata = d; sub_irq = sub;
        @(posedge clk);
        old_eff = eff();
        chg = sub ^ m_subq;
        if (we && a == 8'h50) m_stat = d;
        else m_stat = (m_stat & ~chg) | (sub & chg);
        m_subq = sub;
        gw = 1'b0;
        if (we) begin
            case (a)
                8'h52: m_mask = d;
                8'h54: m_route = d;
                8'h78, 8'h79, 8'h7A: begin m_lvl[8*(a-8'h78) +: 8] = d; gw = 1'b1; end
                8'h7C, 8'h7D, 8'h7E: begin m_en[8*(a-8'h7C) +: 8] = d; gw = 1'b1; end
                8'h98, 8'h99: m_clk[8*(a-8'h98) +: 8] = d;
                8'h9C, 8'h9D, 8'h9E, 8'h9F: m_pll[8*(a-8'h9C) +: 8] = d;
                default: ;
            endcase
        end
        m_evt = gw ? (eff() ^ old_eff) : 16'h0;
        @(negedge clk);
        check(tag_of(a), "rdata", 32'(bus_rdata), 32'(exp_read(a)));
        check("R4", "irq_out", 32'(irq_out), 32'(|(m_stat & m_mask)));
        check("R6", "pin_out", 32'(pin_out), 32'(eff()));
        check("R7", "pin_event", 32'(pin_event), 32'(m_evt));
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] sub;
        logic [7:0] pick [16];
        void'($urandom(32'd4242));
        m_stat = '0; m_mask = '0; m_route = '0; m_subq = '0;
        m_lvl = '0; m_en = '0; m_clk = '0; m_pll = '0; m_evt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        bus_addr = 8'h50;
        #1 check("R10", "status after reset", 32'(bus_rdata), 32'h0);
        check("R10", "irq after reset", 32'(irq_out), 32'h0);
        check("R10", "pins after reset", 32'(pin_out), 32'h0);
        check("R10", "events after reset", 32'(pin_event), 32'h0);
        @(negedge clk);

        // R1: revision bytes, writes ignored
        step(1'b1, 8'h08, 8'h5A, 8'h00);
        step(1'b1, 8'h09, 8'h77, 8'h00);
        step(1'b0, 8'h08, 8'h00, 8'h00);

        // R2/R3/R4: mask, then sub rise and fall
        step(1'b1, 8'h52, 8'h06, 8'h00);
        step(1'b0, 8'h50, 8'h00, 8'h02);
        step(1'b0, 8'h50, 8'h00, 8'h00);
        step(1'b0, 8'h50, 8'h00, 8'h01);
        // R5: software write wins over same-cycle rise
        step(1'b1, 8'h50, 8'h00, 8'h05);
        check("R5", "status after sw priority", 32'(bus_rdata), 32'h00);
        // R5: steady high sub does not re-set after clear
        step(1'b0, 8'h50, 8'h00, 8'h05);
        check("R5", "steady high stays cleared", 32'(bus_rdata), 32'h00);
        step(1'b1, 8'h50, 8'hC4, 8'h05);
        step(1'b0, 8'h50, 8'h00, 8'h00);

        // R6/R7: GPIO enable then bytes
        step(1'b1, 8'h7C, 8'hFF, 8'h00);
        step(1'b1, 8'h7D, 8'hFF, 8'h00);
        step(1'b1, 8'h78, 8'hA5, 8'h00);
        step(1'b1, 8'h79, 8'h3C, 8'h00);
        step(1'b1, 8'h7A, 8'hFF, 8'h00);
        check("R7", "byte 2 write no pulse", 32'(pin_event), 32'h0);
        step(1'b1, 8'h7C, 8'h0F, 8'h00);
        step(1'b0, 8'h78, 8'h00, 8'h00);
        // R8 lanes, R9 holes
        step(1'b1, 8'h99, 8'hBE, 8'h00);
        step(1'b1, 8'h9E, 8'h11, 8'h00);
        step(1'b0, 8'h98, 8'h00, 8'h00);
        step(1'b1, 8'h51, 8'hFF, 8'h00);
        step(1'b1, 8'h7B, 8'hFF, 8'h00);
        step(1'b1, 8'h9A, 8'hFF, 8'h00);

        pick = '{8'h08, 8'h09, 8'h50, 8'h52, 8'h54, 8'h78, 8'h79, 8'h7A,
                 8'h7C, 8'h7D, 8'h7E, 8'h98, 8'h99, 8'h9C, 8'h9D, 8'h9F};
        sub = 8'h00;
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            if (($urandom % 4) == 0) a = 8'($urandom);
            else a = pick[$urandom % 16];
            sub = sub ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            step(($urandom % 3) != 0, a, 8'($urandom), sub);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule